// File: doc/BRIEF.md
# Codec Power and Wake Controller

This block holds the power-management settings for an audio controller and the two serial codecs attached to it. From those settings and the current device power state it drives a dynamic clock-control enable and two clock-gate requests: one for the controller's audio clock and one for the codec bit clock. It also drives a software reset for the digital controller and a write-enable for the identification registers.

While the codecs are powered down and their bit clock is held low, each codec can ask to wake the system by raising its serial data-in line. The block passes each data-in line and the bit clock through a two-flop synchronizer. It then looks for a rising edge on every codec whose wake enable is set, and records the edge in a sticky per-codec status bit. The wake-event output is the OR of those status bits, and software clears them by writing ones.

Software reaches the block through an 8-bit register port with two addresses. Address 0 is the configuration register. Address 1 is the wake status register.

Top module: `codec_pwr_wake`

## Requirements
- R1: After the asynchronous active-low reset, the configuration and wake status read as 0x00 and every output is 0.
- R2: A write to address 0 stores bits 6..0, and bit 7 always reads 0. The outputs follow the stored bits: dynClkCtlEn is bit 0, ctrlSwRst is bit 2 and idWrEn is bit 6.
- R3: ctrlClkGate is 1 exactly when configuration bit 1 (active-low enable) is 0 and pwrState is not D0. The pwrState encoding is 0=D0, 1=D1, 2=D2, 3=D3.
- R4: bitClkGate is 1 exactly when configuration bit 3 (active-low enable) is 0 and pwrState is not D0.
- R5: Bits 4 and 5 are the wake enables for codec 0 and codec 1. A write to address 0 that sets bit 2 (software reset) stores both wake enables as 0, whatever the written data.
- R6: Three conditions must all hold: codecPd is 1, the synchronized bit clock is low, and the codec's wake enable is 1. A rising edge on codecSdin[i] under those conditions then sets wake status bit i (address 1, bit i). The bit and wakeEvent read 1 after the third rising clock edge following the input change.
- R7: No wake status bit is set in any of these cases: the codec's wake enable is 0, codecPd is 0, the bit clock is high, or the data-in line is simply held high with no new rising edge.
- R8: Wake status bits are sticky. A write to address 1 clears only the status bits written as 1. If a wake edge and a clear arrive in the same cycle, the edge wins.
- R9: A write to address 1 leaves the configuration unchanged, and a write to address 0 leaves the wake status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 wake status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for the register selected by regAddr |
| pwrState | input | 2 | Device power state, 0=D0 to 3=D3 |
| codecPd | input | 1 | Codecs are powered down |
| codecBclk | input | 1 | Codec bit clock level (asynchronous) |
| codecSdin | input | 2 | Codec serial data-in lines (asynchronous) |
| dynClkCtlEn | output | 1 | Dynamic clock control enable |
| ctrlClkGate | output | 1 | Request to stop the controller audio clock |
| bitClkGate | output | 1 | Request to stop the codec bit clock |
| ctrlSwRst | output | 1 | Software reset of the digital controller |
| idWrEn | output | 1 | Identification registers writable |
| wakeEvent | output | 1 | A codec has requested wake |

## Verification
Some faults would appear immediately, on the same cycle as the register or power-state change. A corrupted configuration bit shows on the read port and on the gate outputs that way, and so does a gate decode that treats D0 as a low-power state. Wake-path faults show on wakeEvent and on the status read exactly three clock edges after a data-in change, as a missing, early or spurious set. An edge detector that fires on a held level, or that ignores the enable, codecPd or the bit-clock level, produces a wake event that should not appear. A clear that reaches the wrong bit, or that beats a same-cycle edge, leaves the status register wrong at the next read.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic cfgWr;
    logic wakeClr;
  } cpw_strobe_t;

  localparam int CFG_DCC_BIT      = 0;
  localparam int CFG_CTRL_PMN_BIT = 1;
  localparam int CFG_SWRST_BIT    = 2;
  localparam int CFG_CODEC_PMN_BIT = 3;
  localparam int CFG_WAKE_LSB     = 4;
  localparam int CFG_IDWR_BIT     = 6;
  localparam int CFG_USED_W       = 7;
endpackage

// File: rtl/cpw_ctrl.sv
module cpw_ctrl
  import cpw_pkg::*;
(
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [1:0]  pwrState,
  input  logic        ctrlPmEnN,
  input  logic        codecPmEnN,
  output cpw_strobe_t strobe,
  output logic        ctrlClkGate,
  output logic        bitClkGate
);
  logic lowPower;

  always_comb begin
    strobe.cfgWr   = regWrEn && (regAddr == 1'b0);
    strobe.wakeClr = regWrEn && (regAddr == 1'b1);
  end

  // Gating is only permitted outside the fully-on state.
  assign lowPower    = (pwr_state_e'(pwrState) != PS_D0);
  assign ctrlClkGate = lowPower && !ctrlPmEnN;
  assign bitClkGate  = lowPower && !codecPmEnN;
endmodule

// File: rtl/cpw_dpath.sv
module cpw_dpath
  import cpw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_CODECS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cpw_strobe_t           strobe,
  input  logic                  regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  codecPd,
  input  logic                  codecBclk,
  input  logic [NUM_CODECS-1:0] codecSdin,
  output logic [DATA_W-1:0]     cfgQ,
  output logic [NUM_CODECS-1:0] wakeStat,
  output logic [DATA_W-1:0]     regRdData
);
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << CFG_USED_W) - 1);

  logic [DATA_W-1:0]      cfgNext;
  logic [SYNC_STAGES-1:0] bclkSh;
  logic                   bclkLow;
  logic [NUM_CODECS-1:0]  sdinSync;
  logic [NUM_CODECS-1:0]  sdinPrev;
  logic [NUM_CODECS-1:0]  wakeRise;

  // Configuration write: a software reset write clears the wake enables.
  always_comb begin
    cfgNext = regWrData & CFG_MASK;
    if (cfgNext[CFG_SWRST_BIT])
      cfgNext[CFG_WAKE_LSB +: NUM_CODECS] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= '0;
    else if (strobe.cfgWr) cfgQ <= cfgNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bclkSh <= '0;
    else       bclkSh <= {bclkSh[SYNC_STAGES-2:0], codecBclk};
  end
  assign bclkLow = !bclkSh[SYNC_STAGES-1];

  for (genvar gi = 0; gi < NUM_CODECS; gi++) begin : g_codec
    logic [SYNC_STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sh          <= '0;
        sdinPrev[gi] <= 1'b0;
      end else begin
        sh          <= {sh[SYNC_STAGES-2:0], codecSdin[gi]};
        sdinPrev[gi] <= sh[SYNC_STAGES-1];
      end
    end
    assign sdinSync[gi] = sh[SYNC_STAGES-1];

    assign wakeRise[gi] = codecPd && bclkLow && cfgQ[CFG_WAKE_LSB + gi]
                          && sdinSync[gi] && !sdinPrev[gi];

    // Sticky status: a new edge takes priority over a same-cycle clear.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 wakeStat[gi] <= 1'b0;
      else if (wakeRise[gi])                     wakeStat[gi] <= 1'b1;
      else if (strobe.wakeClr && regWrData[gi])  wakeStat[gi] <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) regRdData[NUM_CODECS-1:0] = wakeStat;
    else         regRdData = cfgQ;
  end
endmodule

// File: rtl/codec_pwr_wake.sv
module codec_pwr_wake
  import cpw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_CODECS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [1:0]            pwrState,
  input  logic                  codecPd,
  input  logic                  codecBclk,
  input  logic [NUM_CODECS-1:0] codecSdin,
  output logic                  dynClkCtlEn,
  output logic                  ctrlClkGate,
  output logic                  bitClkGate,
  output logic                  ctrlSwRst,
  output logic                  idWrEn,
  output logic                  wakeEvent
);
  cpw_strobe_t           strobe;
  logic [DATA_W-1:0]     cfgQ;
  logic [NUM_CODECS-1:0] wakeStat;

  cpw_ctrl u_ctrl (
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .pwrState   (pwrState),
    .ctrlPmEnN  (cfgQ[CFG_CTRL_PMN_BIT]),
    .codecPmEnN (cfgQ[CFG_CODEC_PMN_BIT]),
    .strobe     (strobe),
    .ctrlClkGate(ctrlClkGate),
    .bitClkGate (bitClkGate)
  );

  cpw_dpath #(
    .DATA_W     (DATA_W),
    .NUM_CODECS (NUM_CODECS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .codecPd   (codecPd),
    .codecBclk (codecBclk),
    .codecSdin (codecSdin),
    .cfgQ      (cfgQ),
    .wakeStat  (wakeStat),
    .regRdData (regRdData)
  );

  assign dynClkCtlEn = cfgQ[CFG_DCC_BIT];
  assign ctrlSwRst   = cfgQ[CFG_SWRST_BIT];
  assign idWrEn      = cfgQ[CFG_IDWR_BIT];
  assign wakeEvent   = |wakeStat;
endmodule

// File: rtl/cpw_chk.sv
module cpw_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       regAddr,
  input logic [1:0] pwrState,
  input logic       codecPd,
  input logic [1:0] wakeEn,
  input logic       ctrlSwRst,
  input logic       ctrlClkGate,
  input logic       bitClkGate,
  input logic       wakeEvent
);
  // R3 / R4: no clock gating request in D0
  a_r3_no_gate_in_d0: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0) |-> (!ctrlClkGate && !bitClkGate));

  // R5: software reset keeps the wake enables cleared
  a_r5_swrst_clears_wake: assert property (@(posedge clk) disable iff (!rstN)
    ctrlSwRst |-> (wakeEn == 2'b00));

  // R6: a wake event can only appear while codecs are powered down
  a_r6_needs_pd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeEvent) |-> $past(codecPd));

  // R7: a wake event needs an enabled codec
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeEvent) |-> ($past(wakeEn) != 2'b00));

  // R8: wake event stays until a status write
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wakeEvent && !(regWrEn && regAddr)) |=> wakeEvent);
endmodule

bind codec_pwr_wake cpw_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .pwrState   (pwrState),
  .codecPd    (codecPd),
  .wakeEn     (cfgQ[5:4]),
  .ctrlSwRst  (ctrlSwRst),
  .ctrlClkGate(ctrlClkGate),
  .bitClkGate (bitClkGate),
  .wakeEvent  (wakeEvent)
);

// File: tb/codec_pwr_wake_tb.sv
`timescale 1ns/1ps
module codec_pwr_wake_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] pwrState = 2'd0;
  logic       codecPd = 1'b0;
  logic       codecBclk = 1'b0;
  logic [1:0] codecSdin = 2'b00;
  logic       dynClkCtlEn, ctrlClkGate, bitClkGate, ctrlSwRst, idWrEn, wakeEvent;

  int checks = 0;
  int fails = 0;
  logic [7:0] expCfg = '0;
  logic [1:0] expWake = '0;

  always #2.5 clk = ~clk;

  codec_pwr_wake u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwrState(pwrState),
    .codecPd(codecPd), .codecBclk(codecBclk), .codecSdin(codecSdin),
    .dynClkCtlEn(dynClkCtlEn), .ctrlClkGate(ctrlClkGate), .bitClkGate(bitClkGate),
    .ctrlSwRst(ctrlSwRst), .idWrEn(idWrEn), .wakeEvent(wakeEvent)
  );

  function automatic logic [7:0] cfgModel(input logic [7:0] d);
    logic [7:0] e;
    e = d & 8'h7F;
    if (e[2]) e[5:4] = 2'b00;
    return e;
  endfunction

  function automatic logic gateModel(input logic pmN, input logic [1:0] ps);
    return (ps != 2'd0) && !pmN;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic checkAll(input string req);
    regAddr = 1'b0; #0.1;
    check({req, " cfg"}, regRdData, expCfg);
    check({req, " gates"}, {dynClkCtlEn, ctrlClkGate, bitClkGate, ctrlSwRst, idWrEn},
          {expCfg[0], gateModel(expCfg[1], pwrState), gateModel(expCfg[3], pwrState),
           expCfg[2], expCfg[6]});
    regAddr = 1'b1; #0.1;
    check({req, " wake"}, regRdData, {6'b0, expWake});
    check({req, " wakeEvent"}, {7'b0, wakeEvent}, {7'b0, |expWake});
    regAddr = 1'b0;
  endtask

  // Raise one data-in line, sample three edges later, then drop it and settle.
  task automatic pulseSdin(input int i, input logic expectSet, input string req);
    @(negedge clk);
    codecSdin[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (expectSet) expWake[i] = 1'b1;
    checkAll(req);
    codecSdin[i] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R2/R3/R4 random configuration and power state
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wrReg(1'b0, d);
      expCfg = cfgModel(d);
      pwrState = 2'($urandom);
      #0.1;
      checkAll("R2 R3 R4 random");
    end

    // R3 R4 directed: enables active, sweep every power state
    wrReg(1'b0, 8'h00); expCfg = 8'h00;
    for (int p = 0; p < 4; p++) begin
      pwrState = 2'(p); #0.1;
      checkAll("R3 R4 sweep");
    end
    wrReg(1'b0, 8'h0A); expCfg = 8'h0A;
    pwrState = 2'd3; #0.1;
    checkAll("R3 R4 disabled");

    // R5 software reset write wipes wake enables
    wrReg(1'b0, 8'hFF); expCfg = 8'h4F;
    checkAll("R5 swrst");
    pwrState = 2'd0;

    // R6 wake on each codec
    codecPd = 1'b1;
    wrReg(1'b0, 8'h30); expCfg = 8'h30;
    pulseSdin(0, 1'b1, "R6 codec0");
    // R9 config write leaves status
    wrReg(1'b0, 8'h30);
    checkAll("R9 cfg write keeps wake");
    // R8 sticky then selective clear
    wrReg(1'b1, 8'h02);
    checkAll("R8 clear other bit");
    wrReg(1'b1, 8'h01); expWake = 2'b00;
    checkAll("R8 clear");
    pulseSdin(1, 1'b1, "R6 codec1");
    wrReg(1'b1, 8'hFF); expWake = 2'b00;
    checkAll("R9 status write keeps cfg");

    // R7 ignored cases
    wrReg(1'b0, 8'h10); expCfg = 8'h10;
    pulseSdin(1, 1'b0, "R7 disabled codec");
    codecPd = 1'b0;
    pulseSdin(0, 1'b0, "R7 not powered down");
    codecPd = 1'b1;
    codecBclk = 1'b1; repeat (4) @(negedge clk);
    pulseSdin(0, 1'b0, "R7 bit clock high");
    codecBclk = 1'b0; repeat (4) @(negedge clk);
    wrReg(1'b0, 8'h00); expCfg = 8'h00;
    codecSdin[0] = 1'b1; repeat (5) @(negedge clk);
    wrReg(1'b0, 8'h10); expCfg = 8'h10;
    repeat (5) @(negedge clk);
    checkAll("R7 held level");
    codecSdin[0] = 1'b0; repeat (4) @(negedge clk);

    // R8 set beats a same-cycle clear
    @(negedge clk);
    codecSdin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'h01;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    expWake = 2'b01;
    checkAll("R8 set wins");
    codecSdin[0] = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule